// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a general-purpose I/O controller for a parameterised number of pins (64 or 96), arranged in banks of 32. A simple word-addressed register port lets software read the synchronised pin levels, choose the direction of each pin, raise or lower output latches through separate write-one set and clear words, and arm rising and falling edge capture per pin. Captured edges collect in a sticky status word per bank that software acknowledges by writing ones, and any pending status bit raises a single interrupt line.

Each register kind takes a run of consecutive words, one word per bank, so the word address of a register is its kind index times the bank count plus the bank number. On the pin side the block takes the raw input vector and returns an output value vector and an output enable vector. Pin inputs pass through a two-flop synchroniser before they are used.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After synchronous reset every pin is an input (pin_oe all 0), every output latch is 0, both edge enables are 0 for all pins, every status bit is clear and irq is 0.
- R2: With NREG = PINS/32 banks, the word address is kind*NREG + bank, with kinds 0 level, 1 direction, 2 output set, 3 output clear, 4 rising enable, 5 falling enable, 6 edge status; bit k of a word belongs to pin bank*32+k.
- R3: A level read returns the pin input after a two-flop synchroniser: a change driven before clock edge n reads back after edge n+1, whatever the pin direction; writes to level words have no effect.
- R4: The direction word is read/write and drives pin_oe directly, 1 meaning output; pin_oe and pin_out change only on a register write.
- R5: Writing a 1 to a bit of an output set word drives that pin's latch (pin_out) high; 0 bits leave the latch unchanged; set words read as 0.
- R6: Writing a 1 to a bit of an output clear word drives that pin's latch low; 0 bits leave it unchanged; clear words read as 0.
- R7: When a pin's rising enable is 1, a 0-to-1 change of its synchronised input sets its status bit; with the enable 0 a rising change sets nothing.
- R8: The falling enable works on 1-to-0 changes independently of the rising enable; with both enabled either change is captured.
- R9: Status bits are sticky; writing 1 to a status bit clears it and bits written with 0 keep their value.
- R10: When an edge capture and an acknowledge write hit the same status bit in the same cycle, the bit ends up set.
- R11: irq is 1 exactly while any status bit in any bank is 1.
- R12: Addresses at or above 7*NREG read as 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | PINS | Raw pin input samples |
| pin_out | output | PINS | Output latch values |
| pin_oe | output | PINS | Output enables (1 = drive) |
| irq | output | 1 | Combined edge interrupt |

## Verification
A corrupted direction or output latch shows at pin_oe or pin_out in the cycle after the write that caused it, and a wrong enable or status bit shows at the status word and at irq three clock edges after the pin change that should have been captured. The bench keeps a model of every register, rechecks all words and the pin outputs after each random operation, and steers a pin edge into the same edge as an acknowledge write to expose a clear that wins over a capture.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int BANK_W   = 32;
    localparam int NUM_KIND = 7;

    typedef enum logic [2:0] {
        KIND_LEVEL = 3'd0,
        KIND_DIR   = 3'd1,
        KIND_SET   = 3'd2,
        KIND_CLR   = 3'd3,
        KIND_RISE  = 3'd4,
        KIND_FALL  = 3'd5,
        KIND_STAT  = 3'd6
    } reg_kind_e;

    typedef struct packed {
        logic      hit;
        reg_kind_e kind;
        logic [7:0] bank;
    } reg_sel_t;

    typedef struct packed {
        logic [BANK_W-1:0] dir;
        logic [BANK_W-1:0] out;
        logic [BANK_W-1:0] rise;
        logic [BANK_W-1:0] fall;
        logic [BANK_W-1:0] stat;
    } bank_state_t;

    function automatic int word_index(input int kind, input int bank, input int nreg);
        return kind * nreg + bank;
    endfunction

    function automatic logic [BANK_W-1:0] edge_hits(
        input logic [BANK_W-1:0] rise_evt,
        input logic [BANK_W-1:0] fall_evt,
        input logic [BANK_W-1:0] rise_en,
        input logic [BANK_W-1:0] fall_en
    );
        return (rise_evt & rise_en) | (fall_evt & fall_en);
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int PINS = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pin_raw,
    output logic [PINS-1:0] pin_lvl,
    output logic [PINS-1:0] rise_evt,
    output logic [PINS-1:0] fall_evt
);
    logic [PINS-1:0] meta_q;
    logic [PINS-1:0] lvl_q;
    logic [PINS-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            lvl_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pin_raw;
            lvl_q  <= meta_q;
            prev_q <= lvl_q;
        end
    end

    assign pin_lvl  = lvl_q;
    assign rise_evt = lvl_q & ~prev_q;
    assign fall_evt = ~lvl_q & prev_q;
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int NREG   = 2,
    parameter int ADDR_W = 4
) (
    input  logic                   bus_we,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [BANK_W-1:0]      bus_wdata,
    output reg_sel_t               sel,
    output logic [NREG-1:0]        dir_we,
    output logic [NREG-1:0]        rise_we,
    output logic [NREG-1:0]        fall_we,
    output logic [NREG*BANK_W-1:0] set_mask,
    output logic [NREG*BANK_W-1:0] clr_mask,
    output logic [NREG*BANK_W-1:0] ack_mask
);
    always_comb begin
        sel      = '{hit: 1'b0, kind: KIND_LEVEL, bank: 8'd0};
        dir_we   = '0;
        rise_we  = '0;
        fall_we  = '0;
        set_mask = '0;
        clr_mask = '0;
        ack_mask = '0;
        for (int k = 0; k < NUM_KIND; k++) begin
            for (int b = 0; b < NREG; b++) begin
                if (32'(bus_addr) == 32'(word_index(k, b, NREG))) begin
                    sel.hit  = 1'b1;
                    sel.kind = reg_kind_e'(3'(k));
                    sel.bank = 8'(b);
                    if (bus_we) begin
                        case (k)
                            1: dir_we[b]  = 1'b1;
                            2: set_mask[b*BANK_W +: BANK_W] = bus_wdata;
                            3: clr_mask[b*BANK_W +: BANK_W] = bus_wdata;
                            4: rise_we[b] = 1'b1;
                            5: fall_we[b] = 1'b1;
                            6: ack_mask[b*BANK_W +: BANK_W] = bus_wdata;
                            default: ;
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/gpio_bank_slice.sv
module gpio_bank_slice
    import gpio_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] wdata,
    input  logic              dir_we,
    input  logic              rise_we,
    input  logic              fall_we,
    input  logic [BANK_W-1:0] set_mask,
    input  logic [BANK_W-1:0] clr_mask,
    input  logic [BANK_W-1:0] ack_mask,
    input  logic [BANK_W-1:0] rise_evt,
    input  logic [BANK_W-1:0] fall_evt,
    output bank_state_t       state,
    output logic [BANK_W-1:0] capture
);
    bank_state_t st_q;
    bank_state_t st_d;

    assign capture = edge_hits(rise_evt, fall_evt, st_q.rise, st_q.fall);

    always_comb begin
        st_d      = st_q;
        if (dir_we)  st_d.dir  = wdata;
        if (rise_we) st_d.rise = wdata;
        if (fall_we) st_d.fall = wdata;
        st_d.out  = (st_q.out | set_mask) & ~clr_mask;
        st_d.stat = (st_q.stat & ~ack_mask) | capture;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_bank_pkg::*;
#(
    parameter int NREG = 2,
    localparam int PINS = NREG * BANK_W
) (
    input  reg_sel_t          sel,
    input  logic [PINS-1:0]   lvl,
    input  logic [PINS-1:0]   dir,
    input  logic [PINS-1:0]   rise,
    input  logic [PINS-1:0]   fall,
    input  logic [PINS-1:0]   stat,
    output logic [BANK_W-1:0] rdata
);
    function automatic logic [BANK_W-1:0] pick(input logic [PINS-1:0] v, input logic [7:0] bank);
        logic [BANK_W-1:0] w;
        w = '0;
        for (int b = 0; b < NREG; b++) begin
            if (bank == 8'(b)) w = v[b*BANK_W +: BANK_W];
        end
        return w;
    endfunction

    always_comb begin
        rdata = '0;
        if (sel.hit) begin
            case (sel.kind)
                KIND_LEVEL: rdata = pick(lvl,  sel.bank);
                KIND_DIR:   rdata = pick(dir,  sel.bank);
                KIND_RISE:  rdata = pick(rise, sel.bank);
                KIND_FALL:  rdata = pick(fall, sel.bank);
                KIND_STAT:  rdata = pick(stat, sel.bank);
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter  int PINS   = 64,
    localparam int NREG   = PINS / BANK_W,
    localparam int ADDR_W = $clog2(NUM_KIND * NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    logic [PINS-1:0] lvl_all;
    logic [PINS-1:0] rise_evt;
    logic [PINS-1:0] fall_evt;
    reg_sel_t        sel;
    logic [NREG-1:0] dir_we;
    logic [NREG-1:0] rise_we;
    logic [NREG-1:0] fall_we;
    logic [PINS-1:0] set_mask;
    logic [PINS-1:0] clr_mask;
    logic [PINS-1:0] ack_mask;
    logic [PINS-1:0] dir_all;
    logic [PINS-1:0] out_all;
    logic [PINS-1:0] ren_all;
    logic [PINS-1:0] fen_all;
    logic [PINS-1:0] stat_all;
    logic [PINS-1:0] cap_all;

    gpio_pin_sync #(.PINS(PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_raw  (pin_in),
        .pin_lvl  (lvl_all),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    gpio_addr_dec #(.NREG(NREG), .ADDR_W(ADDR_W)) u_dec (
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sel       (sel),
        .dir_we    (dir_we),
        .rise_we   (rise_we),
        .fall_we   (fall_we),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask),
        .ack_mask  (ack_mask)
    );

    for (genvar b = 0; b < NREG; b++) begin : g_bank
        bank_state_t st;
        gpio_bank_slice u_slice (
            .clk      (clk),
            .rst      (rst),
            .wdata    (bus_wdata),
            .dir_we   (dir_we[b]),
            .rise_we  (rise_we[b]),
            .fall_we  (fall_we[b]),
            .set_mask (set_mask[b*BANK_W +: BANK_W]),
            .clr_mask (clr_mask[b*BANK_W +: BANK_W]),
            .ack_mask (ack_mask[b*BANK_W +: BANK_W]),
            .rise_evt (rise_evt[b*BANK_W +: BANK_W]),
            .fall_evt (fall_evt[b*BANK_W +: BANK_W]),
            .state    (st),
            .capture  (cap_all[b*BANK_W +: BANK_W])
        );
        assign dir_all [b*BANK_W +: BANK_W] = st.dir;
        assign out_all [b*BANK_W +: BANK_W] = st.out;
        assign ren_all [b*BANK_W +: BANK_W] = st.rise;
        assign fen_all [b*BANK_W +: BANK_W] = st.fall;
        assign stat_all[b*BANK_W +: BANK_W] = st.stat;
    end

    gpio_read_mux #(.NREG(NREG)) u_rmux (
        .sel   (sel),
        .lvl   (lvl_all),
        .dir   (dir_all),
        .rise  (ren_all),
        .fall  (fen_all),
        .stat  (stat_all),
        .rdata (bus_rdata)
    );

    assign pin_out = out_all;
    assign pin_oe  = dir_all;
    assign irq     = |stat_all;
endmodule

// File: rtl/gpio_bank_checker.sv
module gpio_bank_checker #(
    parameter int PINS = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            bus_we,
    input logic            irq,
    input logic [PINS-1:0] pin_out,
    input logic [PINS-1:0] pin_oe,
    input logic [PINS-1:0] status,
    input logic [PINS-1:0] set_mask,
    input logic [PINS-1:0] clr_mask,
    input logic [PINS-1:0] ack_mask,
    input logic [PINS-1:0] cap_vec
);
    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0 && !irq)); // R1

    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_we |=> ($stable(pin_oe) && $stable(pin_out))); // R4

    AST_SET_HIGH: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((pin_out & $past(set_mask)) == $past(set_mask))); // R5

    AST_CLR_LOW: assert property (@(posedge clk) disable iff (rst)
        (clr_mask != '0) |=> ((pin_out & $past(clr_mask)) == '0)); // R6

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        ((ack_mask & ~cap_vec) != '0) |=> ((status & $past(ack_mask & ~cap_vec)) == '0)); // R9

    AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (rst)
        (cap_vec != '0) |=> ((status & $past(cap_vec)) == $past(cap_vec))); // R10

    AST_IRQ_ON_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (cap_vec != '0) |=> irq); // R11
endmodule

bind gpio_bank_ctrl gpio_bank_checker #(.PINS(PINS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_we   (bus_we),
    .irq      (irq),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .status   (stat_all),
    .set_mask (set_mask),
    .clr_mask (clr_mask),
    .ack_mask (ack_mask),
    .cap_vec  (cap_all)
);

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;
    localparam int PINS   = 64;
    localparam int NREG   = PINS / 32;
    localparam int NWORDS = 7 * NREG;
    localparam int ADDR_W = $clog2(NWORDS);
    localparam int ASPACE = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [PINS-1:0]   pin_in = '0;
    logic [PINS-1:0]   pin_out;
    logic [PINS-1:0]   pin_oe;
    logic              irq;

    int checks = 0;
    int fails  = 0;

    logic [PINS-1:0] pin_m = '0, dir_m = '0, out_m = '0, ren_m = '0, fen_m = '0, st_m = '0;

    always #4 clk = ~clk;

    gpio_bank_ctrl #(.PINS(PINS)) u_gpio_bank_ctrl (
        .clk (clk), .rst (rst), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pin_in (pin_in),
        .pin_out (pin_out), .pin_oe (pin_oe), .irq (irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int a);
        int k, b;
        if (a >= NWORDS) return 32'h0;
        k = a / NREG;
        b = a % NREG;
        case (k)
            0: return pin_m[b*32 +: 32];
            1: return dir_m[b*32 +: 32];
            4: return ren_m[b*32 +: 32];
            5: return fen_m[b*32 +: 32];
            6: return st_m[b*32 +: 32];
            default: return 32'h0;
        endcase
    endfunction

    function automatic string word_req(input int a);
        if (a >= NWORDS) return "R12";
        case (a / NREG)
            0: return "R2/R3 level";
            1: return "R2/R4 dir";
            2: return "R2/R5 set";
            3: return "R2/R6 clr";
            4: return "R2/R7 rise_en";
            5: return "R2/R8 fall_en";
            default: return "R2/R9 status";
        endcase
    endfunction

    task automatic read_now(input int a, output logic [31:0] v);
        bus_addr = ADDR_W'(a);
        #1;
        v = bus_rdata;
    endtask

    task automatic check_all();
        logic [31:0] v;
        for (int a = 0; a < ASPACE; a++) begin
            read_now(a, v);
            chk(word_req(a), 64'(v), 64'(exp_word(a)));
        end
        chk("R5/R6 pin_out", pin_out, out_m);
        chk("R4 pin_oe", pin_oe, dir_m);
        chk("R11 irq", 64'(irq), 64'(st_m != '0));
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        int k, b;
        if (a < NWORDS) begin
            k = a / NREG;
            b = a % NREG;
            case (k)
                1: dir_m[b*32 +: 32] = d;
                2: out_m[b*32 +: 32] = out_m[b*32 +: 32] | d;
                3: out_m[b*32 +: 32] = out_m[b*32 +: 32] & ~d;
                4: ren_m[b*32 +: 32] = d;
                5: fen_m[b*32 +: 32] = d;
                6: st_m[b*32 +: 32]  = st_m[b*32 +: 32] & ~d;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_pins(input logic [PINS-1:0] nv);
        st_m  = st_m | ((~pin_m & nv) & ren_m) | ((pin_m & ~nv) & fen_m);
        pin_m = nv;
        @(negedge clk);
        pin_in = nv;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 pin_oe", pin_oe, '0);
        chk("R1 pin_out", pin_out, '0);
        chk("R1 irq", 64'(irq), 64'(0));
        check_all();

        // R3 two-flop latency on bank 1 bit 0, pin left as input
        @(negedge clk);
        pin_in[32] = 1'b1;
        read_now(NREG * 0 + 1, v); chk("R3 before edge", 64'(v[0]), 64'(0));
        @(negedge clk);
        read_now(1, v); chk("R3 after one edge", 64'(v[0]), 64'(0));
        @(negedge clk);
        read_now(1, v); chk("R3 after two edges", 64'(v[0]), 64'(1));
        pin_m[32] = 1'b1;
        repeat (3) @(negedge clk);
        check_all();

        // R3 level word not writable; R5 and R6 on an output pin
        do_write(0, 32'hFFFF_FFFF);
        do_write(1 * NREG, 32'h0000_00F0);
        do_write(2 * NREG, 32'h0000_0030);
        chk("R5 set", 64'(pin_out[7:4]), 64'h3);
        do_write(3 * NREG, 32'h0000_0010);
        chk("R6 clr", 64'(pin_out[7:4]), 64'h2);
        check_all();

        // R7 rising only on pin 3
        do_write(4 * NREG, 32'h0000_0008);
        do_pins(pin_m | 64'h8);
        chk("R7 rise captured", 64'(irq), 64'(1));
        do_write(6 * NREG, 32'h0000_0008);
        do_pins(pin_m & ~64'h8);
        chk("R7 fall ignored with rise-only", 64'(irq), 64'(0));
        check_all();

        // R8 falling only on pin 4, then both on pin 6
        do_write(5 * NREG, 32'h0000_0050);
        do_pins(pin_m | 64'h10);
        chk("R8 rise ignored with fall-only", 64'(irq), 64'(0));
        do_pins(pin_m & ~64'h10);
        chk("R8 fall captured", 64'(irq), 64'(1));
        do_write(6 * NREG, 32'h0000_0010);
        do_write(4 * NREG, 32'h0000_0048);
        do_pins(pin_m | 64'h40);
        read_now(6 * NREG, v); chk("R8 both: rise", 64'(v[6]), 64'(1));
        do_write(6 * NREG, 32'h0000_0040);
        do_pins(pin_m & ~64'h40);
        read_now(6 * NREG, v); chk("R8 both: fall", 64'(v[6]), 64'(1));
        check_all();

        // R9 acknowledge writing 0 keeps, writing 1 clears
        do_write(6 * NREG, 32'h0000_0000);
        read_now(6 * NREG, v); chk("R9 zero keeps", 64'(v[6]), 64'(1));
        do_write(6 * NREG, 32'h0000_0040);
        read_now(6 * NREG, v); chk("R9 one clears", 64'(v[6]), 64'(0));

        // R10 capture on pin 3 lands on the same edge as its acknowledge
        do_pins(pin_m | 64'h8);
        do_pins(pin_m & ~64'h8);
        @(negedge clk);
        pin_in[3] = 1'b1; pin_m[3] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = ADDR_W'(6 * NREG); bus_wdata = 32'h0000_0008;
        @(negedge clk);
        bus_we = 1'b0;
        read_now(6 * NREG, v); chk("R10 capture beats clear", 64'(v[3]), 64'(1));
        st_m[3] = 1'b1;
        repeat (2) @(negedge clk);
        check_all();

        // R12 out-of-range write ignored
        for (int a = NWORDS; a < ASPACE; a++) do_write(a, 32'hFFFF_FFFF);
        check_all();

        // random mix
        for (int i = 0; i < 250; i++) begin
            int op;
            op = int'($urandom % 5);
            if (op < 3) begin
                do_write(int'($urandom % ASPACE), $urandom);
            end else begin
                logic [PINS-1:0] flip;
                flip = {$urandom, $urandom} & {$urandom, $urandom};
                do_pins(pin_m ^ flip);
            end
            check_all();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule